// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a serial peripheral interface master driven through a small register port. Software first places up to nine bytes in a slot buffer, then writes a command word that picks one of four chip selects, says how many of the bytes are driven out, how many bytes are exchanged in total and whether the chip select stays asserted when the command ends. The block then runs the serial clock at a rate set by a divider field. It shifts the bytes out, and it writes each received bit back into the slot it came from. A status bit stays high until the whole command has finished. After that, software reads the received bytes from the same slots.

Clock polarity and phase, chip-select polarity, bit order and a three-wire mode with one shared data line are all set in the configuration word. Clearing the configuration word stops any transfer and releases every chip-select driver. A transmit count of zero gives a receive-only command. The keep flag lets software chain several nine-byte commands under one unbroken chip-select window.

Top module: `spi_buf_master`

## Requirements
- R1: Register map. The configuration word is at 0x00, status at 0x08 with busy in bit 0, the command word at 0x10, and data slot i (i from 0 to 8) at 0x80 + 8*i in bits 7:0. Slots are written and read back while idle. Unmapped addresses read 0.
- R2: A command write starts a transfer only when the block is enabled (config bit 0), idle, and the total count (command bits 19:16) is nonzero. The total is clamped to 9, and the transmit count (bits 11:8) is clamped to the total.
- R3: The serial clock half-period is D input clocks, with D taken from config bits 28:16 and a value of 0 treated as 1. Busy stays high for exactly (16*N + 2)*D clocks: one setup half-period, 16*N clock halves and one hold half-period.
- R4: The idle clock level is config bit 1 XOR config bit 5, and the clock phase is config bit 5. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1 it is changed on the leading edge and sampled on the trailing edge.
- R5: Bit order is MSB first by default. With config bit 3 set it is LSB first, applied both to the bytes sent and the bytes received.
- R6: The data output driver enable is high only while bytes with index below the transmit count are on the line. A transmit count of 0 leaves the line undriven for the whole command.
- R7: Every received byte k is written into data slot k, for all N bytes of the command.
- R8: With config bit 4 set (three-wire), received bits come from the shared data pin input instead of the separate receive input.
- R9: During a command exactly one chip select, the one given by command bits 1:0, is asserted. Chip selects are active low unless config bit 2 is set. Each chip-select driver enable j is config bit 12+j.
- R10: With the keep flag (command bit 4) clear, the chip select is released when busy falls. With the flag set it stays asserted until a later command ends with the flag clear.
- R11: Writing zero to the configuration word aborts any transfer within one cycle after the write, clears all chip-select driver enables and deasserts every chip select.
- R12: Command writes while busy or disabled, and data slot writes while busy, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| spi_sck | output | 1 | Serial clock |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Data output driver enable |
| spi_sdi | input | 1 | Serial data in (four-wire mode) |
| spi_sdio_in | input | 1 | Shared data pin input (three-wire mode) |
| spi_cs | output | 4 | Chip-select pin levels |
| spi_cs_oe | output | 4 | Chip-select driver enables |

## Verification
On every cycle the assertions check the following. The data driver is only enabled during a command. Exactly one chip select is asserted while busy. The serial clock never moves inside a half-period. Received bits are only written while busy. The chip select is released at the end of a command without the keep flag. A cleared configuration forces the block idle and drops the chip-select driver enables. The bench scenarios are needed for the rest. They check that the bytes a model slave sees and the bytes written back match across all four clock modes, both bit orders and both wiring modes. They also measure busy lengths for several dividers, and show that commands and slot writes issued at the wrong time change nothing.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    localparam int NBYTES  = 9;
    localparam int NCS     = 4;
    localparam int DIVW    = 13;
    localparam int BYTE_IW = $clog2(NBYTES);
    localparam int HCW     = $clog2(NBYTES * 16);
    localparam int CSW     = $clog2(NCS);

    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_STS  = 8'h08;
    localparam logic [7:0] A_CMD  = 8'h10;

    typedef struct packed {
        logic [2:0]      rsv_hi;
        logic [DIVW-1:0] div;
        logic [NCS-1:0]  cs_en;
        logic [5:0]      rsv_mid;
        logic            cpha;
        logic            three_wire;
        logic            lsb_first;
        logic            cs_high;
        logic            pol_xor;
        logic            enable;
    } cfg_t;

    typedef struct packed {
        logic [11:0] rsv3;
        logic [3:0]  total;
        logic [3:0]  rsv2;
        logic [3:0]  txn;
        logic [2:0]  rsv1;
        logic        keep;
        logic [1:0]  rsv0;
        logic [1:0]  csid;
    } cmd_t;

    typedef enum logic [1:0] {ES_IDLE, ES_SETUP, ES_XFER, ES_HOLD} eng_state_t;

    // position of serial bit b inside its byte
    function automatic logic [2:0] bit_pos(input logic [HCW-1:0] b, input logic lsb);
        return lsb ? b[2:0] : ~b[2:0];
    endfunction

endpackage

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_buf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_we,
    input  logic [7:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         busy,
    input  logic                         rx_we,
    input  logic [BYTE_IW-1:0]           rx_byte,
    input  logic [2:0]                   rx_pos,
    input  logic                         rx_val,
    output cfg_t                         cfg,
    output cmd_t                         cmd_next,
    output logic                         start,
    output logic [NBYTES-1:0][7:0]       dbuf
);

    cmd_t        cmd_q;
    cmd_t        cmd_w;
    logic        slot_hit;
    logic [3:0]  slot_idx;
    logic [3:0]  tot_c;

    assign cmd_w    = cmd_t'(reg_wdata);
    assign slot_idx = reg_addr[6:3];
    assign slot_hit = reg_addr[7] && (reg_addr[2:0] == 3'd0) && (int'(slot_idx) < NBYTES);

    always_comb begin
        tot_c    = (int'(cmd_w.total) > NBYTES) ? 4'(NBYTES) : cmd_w.total;
        cmd_next = cmd_w;
        cmd_next.total = tot_c;
        cmd_next.txn   = (cmd_w.txn > tot_c) ? tot_c : cmd_w.txn;
    end

    assign start = reg_we && (reg_addr == A_CMD) && cfg.enable && !busy && (tot_c != 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            cmd_q <= '0;
            dbuf  <= '0;
        end else begin
            if (reg_we && reg_addr == A_CFG)
                cfg <= cfg_t'(reg_wdata);
            if (start)
                cmd_q <= cmd_next;
            if (reg_we && slot_hit && !busy)
                dbuf[BYTE_IW'(slot_idx)] <= reg_wdata[7:0];
            if (rx_we)
                dbuf[rx_byte][rx_pos] <= rx_val;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFG)
            reg_rdata = 32'(cfg);
        else if (reg_addr == A_STS)
            reg_rdata = {31'd0, busy};
        else if (reg_addr == A_CMD)
            reg_rdata = 32'(cmd_q);
        else if (slot_hit)
            reg_rdata = {24'd0, dbuf[BYTE_IW'(slot_idx)]};
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_buf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  cfg_t                   cfg,
    input  logic                   start,
    input  cmd_t                   cmd,
    input  logic [NBYTES-1:0][7:0] dbuf,
    input  logic                   sdi,
    input  logic                   sdio_in,
    output logic                   busy,
    output logic                   sck,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic                   rx_we,
    output logic [BYTE_IW-1:0]     rx_byte,
    output logic [2:0]             rx_pos,
    output logic                   rx_val,
    output logic                   half_start,
    output logic                   in_xfer,
    output logic                   done
);

    eng_state_t      state;
    logic [DIVW-1:0] cnt, div_q;
    logic [HCW-1:0]  hc, last_hc, k, sb, ob;
    logic [3:0]      tot_q, tx_q;
    logic            lsb_q, cpha_q, cpol_q, tw_q;
    logic            div_end, enter, out_bit, out_oe;
    logic [HCW-4:0]  out_byte;

    assign div_end    = (cnt == div_q - DIVW'(1));
    assign last_hc    = (HCW'(tot_q) << 4) - HCW'(1);
    assign enter      = div_end && (state == ES_SETUP || (state == ES_XFER && hc != last_hc));
    assign k          = (state == ES_SETUP) ? '0 : hc + HCW'(1);
    assign sb         = k >> 1;
    assign ob         = cpha_q ? (k >> 1) : ((k + HCW'(1)) >> 1);
    assign out_byte   = ob[HCW-1:3];
    assign out_bit    = (int'(out_byte) < NBYTES) ? dbuf[BYTE_IW'(out_byte)][bit_pos(ob, lsb_q)] : 1'b0;
    assign out_oe     = int'(out_byte) < int'(tx_q);

    assign rx_we      = enter && (k[0] == cpha_q);
    assign rx_byte    = BYTE_IW'(sb[HCW-1:3]);
    assign rx_pos     = bit_pos(sb, lsb_q);
    assign rx_val     = tw_q ? sdio_in : sdi;
    assign busy       = (state != ES_IDLE);
    assign in_xfer    = (state == ES_XFER);
    assign half_start = (cnt == '0);
    assign done       = (state == ES_HOLD) && div_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ES_IDLE;
            cnt    <= '0;
            div_q  <= DIVW'(1);
            hc     <= '0;
            tot_q  <= '0;
            tx_q   <= '0;
            lsb_q  <= 1'b0;
            cpha_q <= 1'b0;
            cpol_q <= 1'b0;
            tw_q   <= 1'b0;
            sck    <= 1'b0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (!cfg.enable) begin
            state  <= ES_IDLE;
            cnt    <= '0;
            sdo_oe <= 1'b0;
            sck    <= cfg.pol_xor ^ cfg.cpha;
        end else if (state == ES_IDLE) begin
            sck    <= cfg.pol_xor ^ cfg.cpha;
            sdo_oe <= 1'b0;
            if (start) begin
                state  <= ES_SETUP;
                cnt    <= '0;
                hc     <= '0;
                div_q  <= (cfg.div == '0) ? DIVW'(1) : cfg.div;
                tot_q  <= cmd.total;
                tx_q   <= cmd.txn;
                lsb_q  <= cfg.lsb_first;
                cpha_q <= cfg.cpha;
                cpol_q <= cfg.pol_xor ^ cfg.cpha;
                tw_q   <= cfg.three_wire;
                sdo    <= dbuf[0][cfg.lsb_first ? 3'd0 : 3'd7];
                sdo_oe <= (cmd.txn != 4'd0);
            end
        end else begin
            cnt <= div_end ? '0 : cnt + DIVW'(1);
            if (enter) begin
                state  <= ES_XFER;
                hc     <= k;
                sck    <= cpol_q ^ ~k[0];
                sdo    <= out_bit;
                sdo_oe <= out_oe;
            end else if (state == ES_XFER && div_end) begin
                state  <= ES_HOLD;
                sck    <= cpol_q;
                sdo_oe <= 1'b0;
            end else if (done) begin
                state  <= ES_IDLE;
            end
        end
    end

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
    import spi_buf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            start,
    input  logic [1:0]      csid,
    input  logic            keep,
    input  logic            done,
    input  logic            busy,
    input  logic            cs_high,
    output logic [NCS-1:0]  cs_vec,
    output logic            keep_q,
    output logic [NCS-1:0]  cs_pins
);

    logic [CSW-1:0] id_q;
    logic           held;
    logic           active;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q   <= '0;
            keep_q <= 1'b0;
            held   <= 1'b0;
        end else if (!enable) begin
            held   <= 1'b0;
        end else if (start) begin
            id_q   <= CSW'(csid);
            keep_q <= keep;
            held   <= 1'b0;
        end else if (done) begin
            held   <= keep_q;
        end
    end

    assign active = busy || held;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_vec[g]  = active && (id_q == CSW'(g));
        assign cs_pins[g] = cs_high ? cs_vec[g] : ~cs_vec[g];
    end

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
    import spi_buf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_sdo,
    output logic        spi_sdo_oe,
    input  logic        spi_sdi,
    input  logic        spi_sdio_in,
    output logic [3:0]  spi_cs,
    output logic [3:0]  spi_cs_oe
);

    cfg_t                   cfg;
    cmd_t                   cmd_next;
    logic                   start, busy, done, rx_we, rx_val;
    logic                   half_start, in_xfer, keep_q, cfg_enable;
    logic [BYTE_IW-1:0]     rx_byte;
    logic [2:0]             rx_pos;
    logic [NBYTES-1:0][7:0] dbuf;
    logic [NCS-1:0]         cs_vec;

    assign cfg_enable = cfg.enable;
    assign spi_cs_oe  = cfg.cs_en;

    spi_regfile u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .rx_we(rx_we), .rx_byte(rx_byte), .rx_pos(rx_pos), .rx_val(rx_val),
        .cfg(cfg), .cmd_next(cmd_next), .start(start), .dbuf(dbuf)
    );

    spi_shift_engine u_eng (
        .clk(clk), .rst(rst), .cfg(cfg), .start(start), .cmd(cmd_next),
        .dbuf(dbuf), .sdi(spi_sdi), .sdio_in(spi_sdio_in), .busy(busy),
        .sck(spi_sck), .sdo(spi_sdo), .sdo_oe(spi_sdo_oe), .rx_we(rx_we),
        .rx_byte(rx_byte), .rx_pos(rx_pos), .rx_val(rx_val),
        .half_start(half_start), .in_xfer(in_xfer), .done(done)
    );

    spi_cs_ctrl u_cs (
        .clk(clk), .rst(rst), .enable(cfg.enable), .start(start),
        .csid(cmd_next.csid), .keep(cmd_next.keep), .done(done), .busy(busy),
        .cs_high(cfg.cs_high), .cs_vec(cs_vec), .keep_q(keep_q), .cs_pins(spi_cs)
    );

endmodule

// File: rtl/spi_buf_master_chk.sv
module spi_buf_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        spi_sck,
    input logic        spi_sdo_oe,
    input logic [3:0]  spi_cs_oe,
    input logic [3:0]  cs_vec,
    input logic        keep_q,
    input logic        in_xfer,
    input logic        half_start,
    input logic        rx_we,
    input logic        cfg_enable,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata
);

    // R6
    sdo_drive_busy_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sdo_oe |-> busy);

    // R9
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(cs_vec) == 1));

    // R3
    sck_half_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && !half_start) |-> $stable(spi_sck));

    // R7
    rx_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rx_we |-> busy);

    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !keep_q) |-> (cs_vec == 4'd0));

    // R11
    cfg_clear_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h00 && reg_wdata == 32'd0) |=> (spi_cs_oe == 4'd0));

    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !$past(cfg_enable)) |-> (!busy && cs_vec == 4'd0));

endmodule

bind spi_buf_master spi_buf_master_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .spi_sck(spi_sck),
    .spi_sdo_oe(spi_sdo_oe), .spi_cs_oe(spi_cs_oe), .cs_vec(cs_vec),
    .keep_q(keep_q), .in_xfer(in_xfer), .half_start(half_start),
    .rx_we(rx_we), .cfg_enable(cfg_enable), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_spi_buf_master.sv
`timescale 1ns/1ps
module tb_spi_buf_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_sdo, spi_sdo_oe, spi_sdi, spi_sdio_in;
    logic [3:0]  spi_cs, spi_cs_oe;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // bench-side slave model state
    bit       b_cpol, b_cpha, b_lsb, b_tw, slv_on;
    int       nl, nt;
    logic     slave_out;
    logic [7:0] resp [9];
    logic [7:0] got  [9];
    bit         oe_seen [9];
    logic [7:0] txb  [9];

    spi_buf_master dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .spi_sdi(spi_sdi),
        .spi_sdio_in(spi_sdio_in), .spi_cs(spi_cs), .spi_cs_oe(spi_cs_oe)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    assign spi_sdi     = b_tw ? ~slave_out : slave_out;
    assign spi_sdio_in = b_tw ? slave_out : ~slave_out;

    function automatic int bpos(int idx);
        return b_lsb ? (idx % 8) : (7 - idx % 8);
    endfunction

    function automatic logic slave_bit();
        int si;
        si = b_cpha ? ((nl == 0) ? 0 : nl - 1) : nt;
        if (si >= 72) return 1'b0;
        return resp[si / 8][bpos(si)];
    endfunction

    function automatic logic [31:0] cfg_word(int div, bit cpol, bit cpha, bit lsb,
                                              bit tw, bit csh, logic [3:0] en);
        return {3'd0, 13'(div), en, 6'd0, cpha, tw, lsb, csh, cpol ^ cpha, 1'b1};
    endfunction

    function automatic logic [31:0] cmd_word(int csid, bit keep, int tx, int tot);
        return {12'd0, 4'(tot), 4'd0, 4'(tx), 3'd0, keep, 2'd0, 2'(csid)};
    endfunction

    task automatic capture(int idx);
        if (idx < 72) begin
            got[idx / 8][bpos(idx)] = spi_sdo;
            if (spi_sdo_oe) oe_seen[idx / 8] = 1'b1;
        end
    endtask

    always @(spi_sck) begin
        if (slv_on) begin
            if (spi_sck != b_cpol) begin
                if (!b_cpha) capture(nl);
                nl++;
            end else begin
                if (b_cpha) capture(nt);
                nt++;
            end
            slave_out = slave_bit();
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // wait for busy to clear; returns posedge count at that point and cs mismatches
    task automatic wait_idle(logic [3:0] exp_cs, output int t1, output int cs_bad);
        cs_bad = 0;
        reg_addr = 8'h08;
        #1;
        while (reg_rdata[0]) begin
            if (spi_cs !== exp_cs) cs_bad++;
            @(negedge clk);
            #1;
        end
        t1 = cyc;
    endtask

    task automatic run_xfer(int csid, bit keep, int n, int tx, int div,
                            bit cpol, bit cpha, bit lsb, bit tw, bit csh);
        int t0, t1, bad, deff;
        logic [31:0] rd;
        logic [3:0] act_cs;
        string tg;
        reg_write(8'h00, cfg_word(div, cpol, cpha, lsb, tw, csh, 4'hF));
        for (int i = 0; i < n; i++) begin
            txb[i] = 8'($urandom);
            reg_write(8'h80 + 8'(8 * i), {24'd0, txb[i]});
        end
        for (int i = 0; i < 9; i++) begin
            resp[i] = 8'($urandom); got[i] = 8'h00; oe_seen[i] = 1'b0;
        end
        b_cpol = cpol; b_cpha = cpha; b_lsb = lsb; b_tw = tw;
        nl = 0; nt = 0;
        slave_out = slave_bit();
        slv_on = 1'b1;
        act_cs = 4'(1 << csid);
        act_cs = csh ? act_cs : ~act_cs;
        reg_write(8'h10, cmd_word(csid, keep, tx, n));
        t0 = cyc;
        wait_idle(act_cs, t1, bad);
        slv_on = 1'b0;
        deff = (div == 0) ? 1 : div;
        check((t1 - t0) == (16 * n + 2) * deff, "R3 busy length", t1 - t0, (16 * n + 2) * deff);
        check(bad == 0, "R9 chip select during command", bad, 0);
        tg = lsb ? "R5 slave received" : "R4 slave received";
        for (int i = 0; i < tx; i++)
            check(got[i] == txb[i], tg, got[i], txb[i]);
        for (int i = 0; i < n; i++)
            check(oe_seen[i] == (i < tx), "R6 driver enable per byte", oe_seen[i], i < tx);
        tg = tw ? "R8 readback" : "R7 readback";
        for (int i = 0; i < n; i++) begin
            reg_read(8'h80 + 8'(8 * i), rd);
            check(rd[7:0] == resp[i], tg, rd[7:0], resp[i]);
        end
        #1;
        check(spi_cs == (keep ? act_cs : {4{~csh}}), "R10 chip select after command",
              spi_cs, keep ? act_cs : {4{~csh}});
        check(spi_sck == cpol, "R4 idle clock level", spi_sck, cpol);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int t0, t1, bad;
        slave_out = 1'b0;
        slv_on = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        reg_read(8'h00, rd); check(rd == 32'd0, "R1 config after reset", rd, 0);
        reg_read(8'h08, rd); check(rd == 32'd0, "R1 status after reset", rd, 0);
        check(spi_cs == 4'hF, "R9 cs idle after reset", spi_cs, 4'hF);
        check(spi_cs_oe == 4'h0, "R9 cs_oe after reset", spi_cs_oe, 0);
        check(spi_sdo_oe == 1'b0, "R6 sdo_oe after reset", spi_sdo_oe, 0);

        // slot readback and unmapped address
        for (int i = 0; i < 9; i++) reg_write(8'h80 + 8'(8 * i), 32'(8'hA0 + i));
        for (int i = 0; i < 9; i++) begin
            reg_read(8'h80 + 8'(8 * i), rd);
            check(rd == 32'(8'hA0 + i), "R1 slot readback", rd, 8'hA0 + i);
        end
        reg_read(8'hC8, rd); check(rd == 32'd0, "R1 unmapped read", rd, 0);

        // command while disabled is ignored
        reg_write(8'h10, cmd_word(0, 0, 1, 1));
        reg_read(8'h08, rd); check(rd[0] == 1'b0, "R12 command while disabled", rd[0], 0);

        // directed: each clock mode, divider zero, full and receive-only
        run_xfer(0, 0, 2, 2, 1, 0, 0, 0, 0, 0);
        run_xfer(1, 0, 3, 3, 2, 1, 0, 0, 0, 0);
        run_xfer(2, 0, 2, 2, 3, 0, 1, 0, 0, 1);
        run_xfer(3, 0, 2, 1, 1, 1, 1, 1, 0, 0);
        run_xfer(0, 0, 9, 9, 0, 0, 0, 0, 0, 0);
        run_xfer(1, 0, 4, 0, 2, 0, 1, 0, 1, 0);
        run_xfer(2, 0, 5, 2, 1, 1, 0, 1, 1, 1);

        // clamping of counts: total 15 -> 9, tx 12 -> 9
        reg_write(8'h00, cfg_word(1, 0, 0, 0, 0, 0, 4'hF));
        reg_write(8'h10, {12'd0, 4'd15, 4'd0, 4'd12, 8'd0});
        t0 = cyc;
        wait_idle(4'hE, t1, bad);
        check((t1 - t0) == 16 * 9 + 2, "R2 total clamp", t1 - t0, 16 * 9 + 2);

        // keep flag chaining on chip select 2
        run_xfer(2, 1, 1, 1, 1, 0, 0, 0, 0, 0);
        run_xfer(2, 0, 1, 1, 1, 0, 0, 0, 0, 0);

        // command and slot write while busy are ignored
        reg_write(8'h00, cfg_word(2, 0, 0, 0, 0, 0, 4'hF));
        reg_write(8'h80 + 8'd64, 32'h5A);
        reg_write(8'h10, cmd_word(1, 0, 2, 2));
        t0 = cyc;
        repeat (4) @(negedge clk);
        reg_write(8'h10, cmd_word(3, 1, 9, 9));
        reg_write(8'h80 + 8'd64, 32'hC3);
        wait_idle(4'hD, t1, bad);
        check((t1 - t0) == (16 * 2 + 2) * 2, "R12 command while busy", t1 - t0, 68);
        check(bad == 0, "R12 cs unchanged while busy", bad, 0);
        reg_read(8'hC0, rd);
        check(rd == 32'h5A, "R12 slot write while busy", rd, 32'h5A);
        check(spi_cs == 4'hF, "R10 released after ignored keep", spi_cs, 4'hF);

        // abort by clearing the configuration
        reg_write(8'h00, cfg_word(4, 0, 0, 0, 0, 0, 4'hF));
        reg_write(8'h10, cmd_word(0, 1, 9, 9));
        repeat (10) @(negedge clk);
        reg_write(8'h00, 32'd0);
        #1 check(spi_cs_oe == 4'h0, "R11 cs_oe cleared", spi_cs_oe, 0);
        reg_read(8'h08, rd);
        check(rd[0] == 1'b0, "R11 busy cleared", rd[0], 0);
        check(spi_cs == 4'hF, "R11 cs released", spi_cs, 4'hF);

        // random transfers with a fixed seed
        void'($urandom(32'h5EED));
        for (int r = 0; r < 20; r++) begin
            int n, tx;
            n  = 1 + int'($urandom % 9);
            tx = int'($urandom % (n + 1));
            run_xfer(int'($urandom % 4), 0, n, tx, int'($urandom % 4),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule